// File: doc/BRIEF.md
# Paged Half-Word Window onto a 32-bit Message Store

This block lets a 16-bit host register bus reach a 256-word, 32-bit message store. The host sees the store as 512 half-words, 128 of which appear at a time in a window at byte addresses 200h to 2FEh. A small page register, at its own byte address, selects which quarter of the store the window shows. Inside a word, the even half-word holds the upper sixteen bits and the odd half-word holds the lower sixteen.

The store is only written as whole words. A host write to an even window location is parked in a holding register. The next write to an odd location joins the parked half with the new lower half and writes the 32-bit result in one cycle. Host reads come straight from the store and never from the holding register. A second port, which only reads, gives an internal sequencer one whole word per cycle.

Top module: `paged_half_bridge`

## Requirements
- R1: After reset the page register reads 0, `host_rdata` is 0 and the holding register is 0, so a lower-half write with no upper-half write before it stores 0000h in bits 31..16.
- R2: A write to the page register (byte address 0F0h) keeps only `host_wdata[1:0]`. A read of that address returns the page in bits 1..0, with bits 15..2 as zero.
- R3: A window write with byte-address bit 1 = 0 (upper half) only loads the holding register. The stored word does not change.
- R4: A window write with byte-address bit 1 = 1 (lower half) stores {holding register, `host_wdata`} as one 32-bit word.
- R5: A window read returns bits 31..16 of the addressed word when address bit 1 is 0, and bits 15..0 when it is 1. The value appears on `host_rdata` one cycle after the request and stays there until the next read.
- R6: The word that a window access reaches is page × 64 + byte-address bits 7..2. The four pages are separate storage.
- R7: A lower-half write reuses whatever upper half was held last. A commit does not clear the holding register.
- R8: A window read of an upper half that has been written but not yet committed returns the stored value, not the held value.
- R9: `sch_rdata` returns the word at `sch_addr` one cycle later. A host commit to that word on clock edge E shows on `sch_rdata` after edge E+1. The read made at edge E still returns the old word.
- R10: Accesses that miss both the window and the page register are ignored. This includes any access with byte-address bit 0 set. Such writes change no word, no page and no held half, and such reads return 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_en | input | 1 | Host access request for this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, registered |
| sch_addr | input | 8 | Sequencer word address |
| sch_rdata | output | 32 | Sequencer read data, registered |

## Verification
The assertions assume that `host_en`, `host_we`, `host_addr` and `host_wdata` are driven to known values from the first clock edge on. They also assume that each request lasts exactly one cycle, so the one-cycle windows they check line up with single accesses. The bench drives every input to zero before reset is released. It changes inputs only on falling edges and drops `host_en` after each access. Every word that is read back is first written in full, so no check depends on uninitialised storage.

// File: rtl/hwpb_pkg.sv
// Shared types for the paged half-word bridge.
// Assumes: one host access per cycle; the kind codes are used only inside the block.
package hwpb_pkg;

    // Classification of the host access in the current cycle
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_PAGE_WR,
        ACC_PAGE_RD,
        ACC_WIN_WR_HI,
        ACC_WIN_WR_LO,
        ACC_WIN_RD,
        ACC_MISS_WR,
        ACC_MISS_RD
    } acc_kind_e;

endpackage

// File: rtl/hwpb_decode.sv
// Host address decoder: sorts each host access into page-register, window
// upper half, window lower half or miss.
// Assumes: WIN_BASE is aligned to the window span; an odd byte address is a miss.
module hwpb_decode
    import hwpb_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 10,
    parameter int unsigned          OFF_W     = 8,
    parameter logic [ADDR_W-1:0]    WIN_BASE  = 10'h200,
    parameter logic [ADDR_W-1:0]    PAGE_ADDR = 10'h0F0
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic              win_hit,
    output logic              page_hit,
    output acc_kind_e         kind
);

    logic aligned;

    // Hit detection for the window span and the page register
    always_comb begin
        aligned  = ~addr[0];
        win_hit  = aligned && (addr[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W]);
        page_hit = aligned && (addr[ADDR_W-1:1] == PAGE_ADDR[ADDR_W-1:1]);
    end

    // Access classification; the page register takes priority over the window
    always_comb begin
        if (!en) begin
            kind = ACC_IDLE;
        end else if (page_hit) begin
            kind = we ? ACC_PAGE_WR : ACC_PAGE_RD;
        end else if (win_hit) begin
            if (we) kind = addr[1] ? ACC_WIN_WR_LO : ACC_WIN_WR_HI;
            else    kind = ACC_WIN_RD;
        end else begin
            kind = we ? ACC_MISS_WR : ACC_MISS_RD;
        end
    end

endmodule

// File: rtl/hwpb_regs.sv
// Page register and upper-half holding register.
// Assumes: load strobes last one cycle; both registers clear on synchronous reset.
module hwpb_regs #(
    parameter int unsigned PAGE_W = 2,
    parameter int unsigned HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_load,
    input  logic [PAGE_W-1:0] page_d,
    input  logic              hold_load,
    input  logic [HALF_W-1:0] hold_d,
    output logic [PAGE_W-1:0] page_q,
    output logic [HALF_W-1:0] hold_q
);

    // Page selection register
    always_ff @(posedge clk) begin
        if (!rst_n)         page_q <= '0;
        else if (page_load) page_q <= page_d;
    end

    // Holding register for the upper half awaiting its commit
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (hold_load) hold_q <= hold_d;
    end

endmodule

// File: rtl/hwpb_store.sv
// Word store with one write port, one combinational read port for the host
// and one registered read port for the sequencer.
// Assumes: storage contents are not reset; the registered port reads before write.
module hwpb_store #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     ha_addr,
    output logic [WORD_W-1:0] ha_data,
    input  logic [AW-1:0]     sb_addr,
    output logic [WORD_W-1:0] sb_data
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Whole-word write
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // Host read port, combinational
    assign ha_data = mem_q[ha_addr];

    // Sequencer read port, one cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n) sb_data <= '0;
        else        sb_data <= mem_q[sb_addr];
    end

endmodule

// File: rtl/paged_half_bridge.sv
// Top level: 16-bit host window onto a 32-bit word store, selected by pages.
// Assumes: host requests last one cycle; even half written before odd half.
module paged_half_bridge
    import hwpb_pkg::*;
#(
    parameter int unsigned       HALF_W     = 16,
    parameter int unsigned       DEPTH      = 256,
    parameter int unsigned       WIN_HALVES = 128,
    parameter int unsigned       ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 10'h200,
    parameter logic [ADDR_W-1:0] PAGE_ADDR  = 10'h0F0,
    localparam int unsigned      WORD_W     = 2 * HALF_W,
    localparam int unsigned      WADDR_W    = $clog2(DEPTH),
    localparam int unsigned      NPAGES     = (2 * DEPTH) / WIN_HALVES,
    localparam int unsigned      PAGE_W     = $clog2(NPAGES),
    localparam int unsigned      OFF_W      = $clog2(WIN_HALVES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_en,
    input  logic               host_we,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [HALF_W-1:0]  host_wdata,
    output logic [HALF_W-1:0]  host_rdata,
    input  logic [WADDR_W-1:0] sch_addr,
    output logic [WORD_W-1:0]  sch_rdata
);

    acc_kind_e          kind;
    logic               win_hit;
    logic               page_hit;
    logic [PAGE_W-1:0]  page_q;
    logic [HALF_W-1:0]  hold_q;
    logic [WADDR_W-1:0] word_addr;
    logic [WORD_W-1:0]  host_word;
    logic               commit_en;
    logic [WORD_W-1:0]  commit_data;

    hwpb_decode #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .WIN_BASE  (WIN_BASE),
        .PAGE_ADDR (PAGE_ADDR)
    ) u_decode (
        .en       (host_en),
        .we       (host_we),
        .addr     (host_addr),
        .win_hit  (win_hit),
        .page_hit (page_hit),
        .kind     (kind)
    );

    hwpb_regs #(
        .PAGE_W (PAGE_W),
        .HALF_W (HALF_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_load (kind == ACC_PAGE_WR),
        .page_d    (host_wdata[PAGE_W-1:0]),
        .hold_load (kind == ACC_WIN_WR_HI),
        .hold_d    (host_wdata),
        .page_q    (page_q),
        .hold_q    (hold_q)
    );

    // Word address from page and window offset; commit word from held and new halves
    always_comb begin
        word_addr   = {page_q, host_addr[OFF_W-1:2]};
        commit_en   = (kind == ACC_WIN_WR_LO);
        commit_data = {hold_q, host_wdata};
    end

    hwpb_store #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .wr_addr (word_addr),
        .wr_data (commit_data),
        .ha_addr (word_addr),
        .ha_data (host_word),
        .sb_addr (sch_addr),
        .sb_data (sch_rdata)
    );

    // Host read data register, loaded on read requests only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else begin
            case (kind)
                ACC_WIN_RD:  host_rdata <= host_addr[1] ? host_word[HALF_W-1:0]
                                                        : host_word[WORD_W-1:HALF_W];
                ACC_PAGE_RD: host_rdata <= HALF_W'(page_q);
                ACC_MISS_RD: host_rdata <= '0;
                default:     host_rdata <= host_rdata;
            endcase
        end
    end

endmodule

// File: rtl/hwpb_checker.sv
// Property checker for paged_half_bridge, attached with bind below.
// Assumes: inputs are known from the first clock edge on.
module hwpb_checker #(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned PAGE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_en,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [HALF_W-1:0] host_wdata,
    input logic [HALF_W-1:0] host_rdata,
    input logic              win_hit,
    input logic              page_hit,
    input logic [PAGE_W-1:0] page_q,
    input logic [HALF_W-1:0] hold_q,
    input logic              commit_en,
    input logic [2*HALF_W-1:0] commit_data
);

    logic pg_wr, hi_wr, lo_wr, any_rd, miss_rd;

    // Request qualifiers taken from the host ports and the decode outputs
    always_comb begin
        pg_wr   = host_en && host_we && page_hit;
        hi_wr   = host_en && host_we && win_hit && !page_hit && !host_addr[1];
        lo_wr   = host_en && host_we && win_hit && !page_hit && host_addr[1];
        any_rd  = host_en && !host_we;
        miss_rd = any_rd && !win_hit && !page_hit;
    end

    assert_page_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pg_wr |=> page_q == $past(host_wdata[PAGE_W-1:0]));

    assert_page_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_wr |=> $stable(page_q));

    assert_hold_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> hold_q == $past(host_wdata));

    assert_hold_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_wr |=> $stable(hold_q));

    assert_commit_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |-> (commit_en && commit_data == {hold_q, host_wdata}));

    assert_no_stray_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_wr |-> !commit_en);

    assert_rdata_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rd |=> $stable(host_rdata));

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        miss_rd |=> host_rdata == '0);

endmodule

bind paged_half_bridge hwpb_checker #(
    .HALF_W (HALF_W),
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
) u_hwpb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_en     (host_en),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .win_hit     (win_hit),
    .page_hit    (page_hit),
    .page_q      (page_q),
    .hold_q      (hold_q),
    .commit_en   (commit_en),
    .commit_data (commit_data)
);

// File: tb/paged_half_bridge_bench.sv
module paged_half_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [7:0]  sch_addr = '0;
    logic [31:0] sch_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    paged_half_bridge u_paged_half_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_en    (host_en),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .sch_addr   (sch_addr),
        .sch_rdata  (sch_rdata)
    );

    // Vector fields: {is_read, byte address, write data or expected read data}
    localparam int NV = 41;
    localparam logic [26:0] VEC [NV] = '{
        {1'b0, 10'h200, 16'h1111},  // page 0 word 0 upper
        {1'b0, 10'h202, 16'h2222},  // page 0 word 0 commit
        {1'b0, 10'h0F0, 16'hFFFD},  // R2 page 1, upper bits dropped
        {1'b1, 10'h0F0, 16'h0001},  // R2
        {1'b0, 10'h200, 16'hAAAA},
        {1'b0, 10'h202, 16'h5555},
        {1'b1, 10'h200, 16'hAAAA},  // R5 upper half
        {1'b1, 10'h202, 16'h5555},  // R5 lower half
        {1'b0, 10'h206, 16'h3333},  // R7 lower with no new upper
        {1'b1, 10'h204, 16'hAAAA},  // R7
        {1'b1, 10'h206, 16'h3333},  // R7
        {1'b0, 10'h0F0, 16'h0000},
        {1'b1, 10'h200, 16'h1111},  // R6 page 0 kept apart from page 1
        {1'b1, 10'h202, 16'h2222},  // R6
        {1'b0, 10'h2FC, 16'h0102},
        {1'b0, 10'h2FE, 16'h0304},
        {1'b0, 10'h2FC, 16'hBEEF},  // held only
        {1'b1, 10'h2FC, 16'h0102},  // R8 read ignores held half
        {1'b1, 10'h2FE, 16'h0304},  // R3 word unchanged
        {1'b0, 10'h2FE, 16'h0506},
        {1'b1, 10'h2FC, 16'hBEEF},  // R4
        {1'b1, 10'h2FE, 16'h0506},  // R4
        {1'b0, 10'h100, 16'h7777},  // miss write
        {1'b1, 10'h0F0, 16'h0000},  // R10 page untouched
        {1'b1, 10'h200, 16'h1111},  // R10
        {1'b1, 10'h100, 16'h0000},  // R10 miss read
        {1'b0, 10'h300, 16'h9999},  // outside window
        {1'b0, 10'h302, 16'h8888},
        {1'b1, 10'h302, 16'h0000},  // R10
        {1'b1, 10'h202, 16'h2222},  // R10 no commit happened
        {1'b0, 10'h201, 16'h6666},  // odd byte address ignored
        {1'b1, 10'h201, 16'h0000},  // R10
        {1'b0, 10'h206, 16'h4444},  // commit with held half
        {1'b1, 10'h204, 16'hBEEF},  // R10 held half not touched by misses
        {1'b0, 10'h0F0, 16'h0003},
        {1'b0, 10'h2FC, 16'hCAFE},
        {1'b0, 10'h2FE, 16'hF00D},  // last word of the store
        {1'b1, 10'h2FE, 16'hF00D},  // R6
        {1'b1, 10'h0F0, 16'h0003},  // R2
        {1'b0, 10'h0F0, 16'h0001},
        {1'b1, 10'h200, 16'hAAAA}   // R6
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input logic [9:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_en = 1'b0;
        check(host_rdata == exp, req, {16'h0, host_rdata}, {16'h0, exp});
    endtask

    task automatic sch_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        sch_addr = a;
        @(negedge clk);
        check(sch_rdata == exp, req, sch_rdata, exp);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check(host_rdata == 16'h0, "R1", {16'h0, host_rdata}, 32'h0);
        host_read(10'h0F0, 16'h0000, "R1");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][26])
                host_read(VEC[i][25:16], VEC[i][15:0], $sformatf("vector %0d", i));
            else
                host_write(VEC[i][25:16], VEC[i][15:0]);
        end

        // R5: read data held while no read is made
        repeat (3) @(negedge clk);
        check(host_rdata == 16'hAAAA, "R5", {16'h0, host_rdata}, 32'h0000AAAA);

        // R9 and R6: sequencer port sees committed words
        sch_read(8'd255, 32'hCAFEF00D, "R9");
        sch_read(8'd64, 32'hAAAA5555, "R6");
        sch_read(8'd65, 32'hAAAA3333, "R7");

        // R9: commit at edge E, old word at E, new word after E+1 (page is 1)
        host_write(10'h208, 16'h1234);
        host_write(10'h20A, 16'h5678);
        @(negedge clk);
        sch_addr = 8'd66;
        host_write(10'h208, 16'h9ABC);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = 10'h20A; host_wdata = 16'hDEF0;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
        check(sch_rdata == 32'h12345678, "R9", sch_rdata, 32'h12345678);
        @(negedge clk);
        check(sch_rdata == 32'h9ABCDEF0, "R9", sch_rdata, 32'h9ABCDEF0);

        // R1: reset again clears page and held half (held is CAFE before this)
        host_write(10'h2FC, 16'hCAFE);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_rdata == 16'h0, "R1", {16'h0, host_rdata}, 32'h0);
        host_read(10'h0F0, 16'h0000, "R1");
        host_write(10'h202, 16'hABCD);
        host_read(10'h200, 16'h0000, "R1");
        sch_read(8'd0, 32'h0000ABCD, "R1");

        finish_run();
    end

endmodule